// File: doc/BRIEF.md
# Scrunching Systolic Event Priority Queue

This block keeps a time-ordered calendar of pending events in a linear array of `DEPTH` slots, with the earliest event in slot 0. Each event carries a 32-bit time tag and a 26-bit payload. The payload holds two 13-bit bead identifiers, one for each of the two particles that the event involves. In every clock cycle the array can take one new event, hand one event out from the head, and apply a broadcast invalidation that names one bead. Every slot compares its own entry against the broadcast and the incoming tag, so insertion, invalidation and advance all complete in the same cycle, whatever the depth.

An invalidation can remove any number of entries at once, and each removed entry leaves an empty slot behind. The array does not run a separate pass to close these gaps. Each entry simply moves toward the head on every cycle by as many empty slots as lie ahead of it, up to two. Gaps therefore drain toward the tail within a few cycles, and the array never stops to do it. When a gap reaches the head and a dequeue is requested in that cycle, the output reports no event. It does not stall.

A controller that commits events in time order uses the block as follows. It dequeues every cycle, broadcasts the beads of the committed event for invalidation, and pushes newly predicted events back in.

Top module: `scrunch_event_queue`

## Requirements
- R1: After reset every slot is empty, `pop_valid` and `overflow` are low, and a dequeue request returns no event.
- R2: When `pop_en` is high, the next cycle shows the earliest live event on `pop_tag`/`pop_bead_a`/`pop_bead_b` with `pop_valid` high. Events leave in nondecreasing tag order, and `pop_valid` is never high unless `pop_en` was high in the cycle before.
- R3: A pushed event whose tag equals the tag of one or more stored events is placed behind all of them, so equal tags leave in push order.
- R4: When `kill_en` is high, every stored entry whose `bead_a` or `bead_b` equals `kill_bead` is removed in that cycle, however many entries match, and never leaves the queue. An event pushed in the same cycle is not affected by that broadcast.
- R5: If the head slot is empty after this cycle's invalidation when a dequeue is requested, `pop_valid` is low in the next cycle and no live event is lost. Every live event still leaves later.
- R6: When no slot at or behind the new event's ordered position is free, including the case where all `DEPTH` slots hold live entries, the push is refused. `overflow` is then high for exactly the next cycle, and the refused event never appears.
- R7: An accepted push never displaces or drops a stored entry. With no dequeue and no invalidation, the live count rises by exactly one.
- R8: With `DEPTH` at least 8, a gap-free queue sustains one dequeue per cycle. `pop_valid` stays high on consecutive cycles while pushes and dequeues happen together.
- R9: A pushed event with a tag earlier than every stored tag is placed at the head and is the next event dequeued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_en | input | 1 | Offer a new event this cycle |
| push_tag | input | 32 | Time tag of the new event |
| push_bead_a | input | 13 | First bead identifier of the new event |
| push_bead_b | input | 13 | Second bead identifier of the new event |
| kill_en | input | 1 | Broadcast an invalidation this cycle |
| kill_bead | input | 13 | Bead whose stored events are removed |
| pop_en | input | 1 | Dequeue the head slot this cycle |
| pop_valid | output | 1 | Dequeued event is present (one cycle after `pop_en`) |
| pop_tag | output | 32 | Time tag of the dequeued event |
| pop_bead_a | output | 13 | First bead of the dequeued event |
| pop_bead_b | output | 13 | Second bead of the dequeued event |
| overflow | output | 1 | One-cycle pulse: the previous cycle's push was refused |

## Verification
The assertions check four properties on every cycle. The stored entries stay in tag order. No entry that matches a broadcast bead survives the broadcast. A full, untouched array refuses a push, and an accepted push raises the live count by one. A dequeue that finds an empty head yields no event. Other behaviours can only be shown by the bench's scenarios running against a sorted reference list. These are the order among equal tags, the jump of an early tag to the head, an unbroken run of dequeues, and the fact that every live event eventually leaves even after heavy random invalidation.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int TAG_W  = 32;
  localparam int BEAD_W = 13;

  typedef struct packed {
    logic              vld;
    logic [TAG_W-1:0]  tag;
    logic [BEAD_W-1:0] bead_a;
    logic [BEAD_W-1:0] bead_b;
  } evq_entry_t;

  // stored entry stays ahead of a newcomer with tag t_new (ties keep arrival order)
  function automatic logic evq_stays_ahead(logic [TAG_W-1:0] t_old, logic [TAG_W-1:0] t_new);
    return t_old <= t_new;
  endfunction

  // a live entry is hit by a broadcast when either bead matches
  function automatic logic evq_bead_hit(evq_entry_t e, logic [BEAD_W-1:0] b);
    return e.vld && (e.bead_a == b || e.bead_b == b);
  endfunction
endpackage

// File: rtl/evq_slot_probe.sv
module evq_slot_probe
  import evq_pkg::*;
(
  input  evq_entry_t        ent,
  input  logic              kill_en,
  input  logic [BEAD_W-1:0] kill_bead,
  output logic              hit
);
  // R4: local associative compare against the broadcast bead
  assign hit = kill_en & evq_bead_hit(ent, kill_bead);
endmodule

// File: rtl/evq_compactor.sv
module evq_compactor
  import evq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  evq_entry_t [DEPTH-1:0] src,
  output evq_entry_t [DEPTH-1:0] dst,
  output logic       [DEPTH-1:0] gap_one,
  output logic       [DEPTH-1:0] gap_two
);
  // gap_one[j]: at least one empty slot ahead of j; gap_two[j]: at least two
  always_comb begin
    logic seen1;
    logic seen2;
    seen1 = 1'b0;
    seen2 = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      gap_one[j] = seen1;
      gap_two[j] = seen2;
      if (!src[j].vld) begin
        seen2 = seen2 | seen1;
        seen1 = 1'b1;
      end
    end
  end

  // each entry advances by min(2, gaps ahead); slot j gathers from j, j+1 or j+2
  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    evq_entry_t from1;
    evq_entry_t from2;
    logic       take1;
    logic       take2;
    logic       keep;
    if (j + 1 < DEPTH) begin : g_n1
      assign from1 = src[j+1];
      assign take1 = src[j+1].vld & gap_one[j+1] & ~gap_two[j+1];
    end else begin : g_n1_none
      assign from1 = '0;
      assign take1 = 1'b0;
    end
    if (j + 2 < DEPTH) begin : g_n2
      assign from2 = src[j+2];
      assign take2 = src[j+2].vld & gap_two[j+2];
    end else begin : g_n2_none
      assign from2 = '0;
      assign take2 = 1'b0;
    end
    assign keep   = src[j].vld & ~gap_one[j];
    assign dst[j] = take2 ? from2 : take1 ? from1 : keep ? src[j] : '0;
  end
endmodule

// File: rtl/evq_insert_net.sv
module evq_insert_net
  import evq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  evq_entry_t [DEPTH-1:0] cur,
  input  logic                   ins_en,
  input  evq_entry_t             ins_ent,
  output evq_entry_t [DEPTH-1:0] nxt,
  output logic                   accept,
  output logic                   refuse
);
  logic [DEPTH-1:0] ahead_suf;  // some live entry at >= j stays ahead of newcomer
  logic [DEPTH-1:0] land;       // newcomer's ordered slot
  logic [DEPTH-1:0] push_in;    // slot j receives cur[j-1] pushed back
  logic             spill;      // displacement chain ran off the tail

  always_comb begin
    logic run;
    logic prev;
    run = 1'b0;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      run = run | (cur[j].vld & evq_stays_ahead(cur[j].tag, ins_ent.tag));
      ahead_suf[j] = run;
    end
    prev = 1'b1;
    for (int j = 0; j < DEPTH; j++) begin
      land[j] = ~ahead_suf[j] & prev;  // R3: equal tags stay ahead
      prev = ahead_suf[j];
    end
    run = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      push_in[j] = run;
      run = (land[j] | push_in[j]) & cur[j].vld;  // chain ends at first free slot
    end
    spill = run;
  end

  // R6: no place for the newcomer, or shifting would drop the tail entry
  assign refuse = ins_en & (~(|land) | spill);
  assign accept = ins_en & ~refuse;

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    evq_entry_t behind;
    if (j > 0) begin : g_prev
      assign behind = cur[j-1];
    end else begin : g_head
      assign behind = '0;
    end
    assign nxt[j] = (accept & land[j])    ? ins_ent :
                    (accept & push_in[j]) ? behind  : cur[j];
  end
endmodule

// File: rtl/scrunch_event_queue.sv
module scrunch_event_queue
  import evq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic [BEAD_W-1:0] push_bead_a,
  input  logic [BEAD_W-1:0] push_bead_b,
  input  logic              kill_en,
  input  logic [BEAD_W-1:0] kill_bead,
  input  logic              pop_en,
  output logic              pop_valid,
  output logic [TAG_W-1:0]  pop_tag,
  output logic [BEAD_W-1:0] pop_bead_a,
  output logic [BEAD_W-1:0] pop_bead_b,
  output logic              overflow
);
  evq_entry_t [DEPTH-1:0] slots_q;
  evq_entry_t [DEPTH-1:0] thinned;   // after broadcast kill and head removal
  evq_entry_t [DEPTH-1:0] squeezed;  // after gap advance
  evq_entry_t [DEPTH-1:0] slots_d;
  logic       [DEPTH-1:0] kill_hit;
  logic       [DEPTH-1:0] gap_one;
  logic       [DEPTH-1:0] gap_two;
  logic                   head_take;
  logic                   push_accept;
  logic                   push_refuse;
  evq_entry_t             push_ent;

  assign push_ent = '{vld: 1'b1, tag: push_tag, bead_a: push_bead_a, bead_b: push_bead_b};

  for (genvar j = 0; j < DEPTH; j++) begin : g_cell
    evq_slot_probe u_probe (
      .ent       (slots_q[j]),
      .kill_en   (kill_en),
      .kill_bead (kill_bead),
      .hit       (kill_hit[j])
    );
    assign thinned[j] = {slots_q[j].vld & ~kill_hit[j] & ~((j == 0) & pop_en),
                         slots_q[j].tag, slots_q[j].bead_a, slots_q[j].bead_b};
  end

  // R2/R5: head leaves only if live after this cycle's kill
  assign head_take = pop_en & slots_q[0].vld & ~kill_hit[0];

  evq_compactor #(.DEPTH(DEPTH)) u_squeeze (
    .src     (thinned),
    .dst     (squeezed),
    .gap_one (gap_one),
    .gap_two (gap_two)
  );

  evq_insert_net #(.DEPTH(DEPTH)) u_insert (
    .cur     (squeezed),
    .ins_en  (push_en),
    .ins_ent (push_ent),
    .nxt     (slots_d),
    .accept  (push_accept),
    .refuse  (push_refuse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin  // R1
      slots_q    <= '0;
      pop_valid  <= 1'b0;
      pop_tag    <= '0;
      pop_bead_a <= '0;
      pop_bead_b <= '0;
      overflow   <= 1'b0;
    end else begin
      slots_q    <= slots_d;
      pop_valid  <= head_take;
      pop_tag    <= head_take ? slots_q[0].tag    : '0;
      pop_bead_a <= head_take ? slots_q[0].bead_a : '0;
      pop_bead_b <= head_take ? slots_q[0].bead_b : '0;
      overflow   <= push_refuse;
    end
  end
endmodule

// File: rtl/evq_checker.sv
module evq_checker
  import evq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   push_en,
  input logic [BEAD_W-1:0]      push_bead_a,
  input logic [BEAD_W-1:0]      push_bead_b,
  input logic                   kill_en,
  input logic [BEAD_W-1:0]      kill_bead,
  input logic                   pop_en,
  input logic                   pop_valid,
  input logic                   overflow,
  input evq_entry_t [DEPTH-1:0] slots
);
  logic [DEPTH-1:0] occ;
  for (genvar j = 0; j < DEPTH; j++) begin : g_occ
    assign occ[j] = slots[j].vld;
  end

  function automatic logic in_order(evq_entry_t [DEPTH-1:0] s);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DEPTH; i++)
      for (int k = i + 1; k < DEPTH; k++)
        if (s[i].vld && s[k].vld && s[i].tag > s[k].tag) ok = 1'b0;
    return ok;
  endfunction

  function automatic int hits(evq_entry_t [DEPTH-1:0] s, logic [BEAD_W-1:0] b);
    int n;
    n = 0;
    for (int i = 0; i < DEPTH; i++)
      if (evq_bead_hit(s[i], b)) n++;
    return n;
  endfunction

  logic push_has_kill;
  assign push_has_kill = push_en && (push_bead_a == kill_bead || push_bead_b == kill_bead);

  assert_sorted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_order(slots));

  assert_pop_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> $past(pop_en));

  assert_kill_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_en && !push_has_kill) |=> hits(slots, $past(kill_bead)) == 0);

  assert_head_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !occ[0]) |=> !pop_valid);

  assert_full_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((&occ) && push_en && !pop_en && !kill_en) |=> overflow);

  assert_refuse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(push_en));

  assert_count_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !pop_en && !kill_en) |=>
      (overflow || $countones(occ) == $past($countones(occ)) + 1));
endmodule

bind scrunch_event_queue evq_checker #(.DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_en     (push_en),
  .push_bead_a (push_bead_a),
  .push_bead_b (push_bead_b),
  .kill_en     (kill_en),
  .kill_bead   (kill_bead),
  .pop_en      (pop_en),
  .pop_valid   (pop_valid),
  .overflow    (overflow),
  .slots       (slots_q)
);

// File: tb/scrunch_event_queue_tb_top.sv
module scrunch_event_queue_tb_top;
  import evq_pkg::*;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_en = 1'b0;
  logic [TAG_W-1:0] push_tag = '0;
  logic [BEAD_W-1:0] push_bead_a = '0;
  logic [BEAD_W-1:0] push_bead_b = '0;
  logic kill_en = 1'b0;
  logic [BEAD_W-1:0] kill_bead = '0;
  logic pop_en = 1'b0;
  logic pop_valid;
  logic [TAG_W-1:0] pop_tag;
  logic [BEAD_W-1:0] pop_bead_a;
  logic [BEAD_W-1:0] pop_bead_b;
  logic overflow;

  always #10 clk = ~clk;

  scrunch_event_queue #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_tag(push_tag),
    .push_bead_a(push_bead_a), .push_bead_b(push_bead_b), .kill_en(kill_en),
    .kill_bead(kill_bead), .pop_en(pop_en), .pop_valid(pop_valid), .pop_tag(pop_tag),
    .pop_bead_a(pop_bead_a), .pop_bead_b(pop_bead_b), .overflow(overflow)
  );

  evq_entry_t exp_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  string req = "R1";
  bit    done = 1'b0;

  task automatic check(bit ok, string r, string what, longint act, longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // reference: stable sorted insertion, ties go behind
  function automatic void ref_insert(evq_entry_t e);
    int idx;
    idx = exp_q.size();
    for (int i = 0; i < exp_q.size(); i++)
      if (exp_q[i].tag > e.tag) begin idx = i; break; end
    exp_q.insert(idx, e);
  endfunction

  function automatic void ref_kill(logic [BEAD_W-1:0] b);
    for (int i = exp_q.size() - 1; i >= 0; i--)
      if (exp_q[i].bead_a == b || exp_q[i].bead_b == b) exp_q.delete(i);
  endfunction

  // monitor: compares what the design produced at the last edge against the reference
  task automatic monitor(bit ie, evq_entry_t ne, bit ke, logic [BEAD_W-1:0] kb, bit de);
    int sz;
    if (ke) ref_kill(kb);
    if (pop_valid) begin
      if (!de) check(1'b0, "R2", "pop_valid without request", 1, 0);
      else if (exp_q.size() == 0) check(1'b0, req, "event from empty reference", pop_tag, 0);
      else begin
        check(pop_tag == exp_q[0].tag, req, "dequeued tag", pop_tag, exp_q[0].tag);
        check({pop_bead_a, pop_bead_b} == {exp_q[0].bead_a, exp_q[0].bead_b}, req,
              "dequeued beads", {pop_bead_a, pop_bead_b}, {exp_q[0].bead_a, exp_q[0].bead_b});
        void'(exp_q.pop_front());
      end
    end
    sz = exp_q.size();
    if (overflow) begin
      if (!ie) check(1'b0, "R6", "overflow without push", 1, 0);
      else if (sz < DEPTH / 2) check(1'b0, "R6", "refused with room", sz, DEPTH);
    end else if (ie) begin
      if (sz >= DEPTH) check(1'b0, "R6", "accepted into full queue", sz, DEPTH - 1);
      else ref_insert(ne);
    end
  endtask

  // driver: applies one cycle of stimulus, then runs the monitor away from the edge
  task automatic step(bit ie, int tag, int a, int b, bit ke, int kb, bit de);
    evq_entry_t ne;
    ne = '{vld: 1'b1, tag: TAG_W'(tag), bead_a: BEAD_W'(a), bead_b: BEAD_W'(b)};
    push_en = ie; push_tag = ne.tag; push_bead_a = ne.bead_a; push_bead_b = ne.bead_b;
    kill_en = ke; kill_bead = BEAD_W'(kb); pop_en = de;
    @(posedge clk);
    @(negedge clk);
    push_en = 1'b0; kill_en = 1'b0; pop_en = 1'b0;
    monitor(ie, ne, ke, BEAD_W'(kb), de);
  endtask

  task automatic push(int tag, int a, int b);
    step(1'b1, tag, a, b, 1'b0, 0, 1'b0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 1'b0, 0, 1'b0);
  endtask

  task automatic drain(string r);
    for (int i = 0; i < 4 * DEPTH && exp_q.size() > 0; i++) step(1'b0, 0, 0, 0, 1'b0, 0, 1'b1);
    check(exp_q.size() == 0, r, "events left after drain", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired in %s actual=1 expected=0", req);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    req = "R1";
    check(pop_valid == 1'b0, "R1", "pop_valid after reset", pop_valid, 0);
    check(overflow == 1'b0, "R1", "overflow after reset", overflow, 0);
    step(1'b0, 0, 0, 0, 1'b0, 0, 1'b1);
    check(pop_valid == 1'b0, "R1", "dequeue from empty", pop_valid, 0);

    // R2, R3: order and ties
    req = "R3";
    push(50, 1, 2); push(20, 3, 4); push(80, 5, 6); push(20, 7, 8); push(35, 9, 10); push(20, 11, 12);
    idle(3);
    drain("R2");

    // R9: earliest tag jumps to the head
    req = "R9";
    push(100, 1, 1); push(200, 2, 2); idle(2); push(5, 3, 3); idle(1);
    step(1'b0, 0, 0, 0, 1'b0, 0, 1'b1);
    check(pop_valid && pop_tag == 5, "R9", "early tag first", pop_tag, 5);
    drain("R9");

    // R4: many matches in one broadcast, same-cycle push survives
    req = "R4";
    push(10, 7, 1); push(20, 2, 7); push(30, 3, 4); push(40, 7, 7); push(50, 5, 6); idle(2);
    step(1'b1, 25, 7, 9, 1'b1, 7, 1'b0);
    check(exp_q.size() == 3, "R4", "survivors after kill", exp_q.size(), 3);
    idle(3);
    drain("R4");

    // R5: head killed in the cycle of a dequeue
    req = "R5";
    push(10, 3, 0); push(20, 4, 0); idle(3);
    step(1'b0, 0, 0, 0, 1'b1, 3, 1'b1);
    check(pop_valid == 1'b0, "R5", "hole at head yields no event", pop_valid, 0);
    step(1'b0, 0, 0, 0, 1'b0, 0, 1'b1);
    check(pop_valid && pop_tag == 20, "R5", "next live event", pop_tag, 20);

    // R6: full array refuses, pulse lasts one cycle
    req = "R6";
    for (int i = 0; i < DEPTH; i++) push(100 + 3 * i, i, i + 100);
    idle(4);
    push(9999, 1, 1);
    check(overflow == 1'b1, "R6", "late tag refused when full", overflow, 1);
    push(1, 1, 1);
    check(overflow == 1'b1, "R6", "early tag refused when full", overflow, 1);
    idle(1);
    check(overflow == 1'b0, "R6", "overflow is a single pulse", overflow, 0);
    check(exp_q.size() == DEPTH, "R7", "no entry lost on refusal", exp_q.size(), DEPTH);
    drain("R6");

    // R8: back-to-back dequeue with simultaneous pushes
    req = "R8";
    for (int i = 0; i < 8; i++) push(10 * i, i, i);
    idle(2 * DEPTH);
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 1000 + i, 20 + i, 40 + i, 1'b0, 0, 1'b1);
      check(pop_valid == 1'b1, "R8", "consecutive dequeue", pop_valid, 1);
    end
    idle(4);
    drain("R8");

    // R5, R7: random traffic against the reference
    req = "R7";
    for (int i = 0; i < 600; i++) begin
      bit ie, ke, de;
      ie = ($urandom_range(0, 9) < 5) && (exp_q.size() < DEPTH / 2 - 2);
      ke = ($urandom_range(0, 9) < 1);
      de = ($urandom_range(0, 9) < 5);
      step(ie, int'($urandom_range(0, 63)), int'($urandom_range(0, 15)),
           int'($urandom_range(0, 15)), ke, int'($urandom_range(0, 15)), de);
    end
    idle(4);
    drain("R5");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule